// File: doc/BRIEF.md
# Two-wire bus recovery sequencer

This block frees an open-drain two-wire bus that a slave device has left stuck, typically because the master was reset partway through a transfer and the slave is still holding SDA low while it waits for clocks. Once launched, it drives a fixed pattern on the two lines. It first makes a start condition. It then gives nine SCL clocks with SDA released, which looks like an all-ones byte to the slave. It ends with a repeated start and a stop. The nine clocks let the stuck slave finish its byte and its acknowledge bit. The repeated start then returns the slave's protocol logic to its idle state.

The sequence runs once by itself when reset is released, before the bus carries any normal traffic. It can be run again at any time by pulsing `trigger`. Each line is controlled through a pull-low enable and a sampled line value. The block never drives a line high: it releases the line and the bus pull-up takes it high. Every SCL-low and SCL-high step lasts a programmable number of system clocks. A step in which SCL is released counts only while the sampled SCL reads high, so a slave that stretches the clock is respected. When the stop is complete, `done` pulses and `sda_free` reports whether SDA was high at that point.

Top module: `twi_recover_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `scl_pull`, `sda_pull`, `busy` and `done` are all 0.
- R2: With parameter AUTO_RUN=1, a full sequence starts at the first clock edge after reset is released, without any trigger.
- R3: Each run makes exactly two SDA pull-low edges while SCL is released (the start, then the repeated start). It makes exactly one SDA release while SCL is released (the stop), and the stop is last.
- R4: Each run releases SCL exactly CLOCKS+2 times after holding it low (default 11): the nine clock pulses, the repeated-start high phase and the stop high phase.
- R5: During the high phases of the nine clock pulses, `sda_pull` is 0.
- R6: Each step lasts max(half_period,1) cycles. A run without stretching keeps `busy` high for 27*max(half_period,1) cycles.
- R7: While SCL is released but reads low, the pulls do not change. Each cycle of stretching adds one cycle to the run.
- R8: A `trigger` that arrives while `busy` is high is ignored. It neither restarts nor queues a run.
- R9: `busy` rises at the edge that accepts the trigger. `done` is a single-cycle pulse in the first cycle in which `busy` is low again, and `busy` only falls together with `done`.
- R10: `sda_free` takes the value that `sda_in` has at the end of the stop step and holds it until the next `done`.
- R11: `scl_pull` and `sda_pull` never change in the same cycle, and both are 0 whenever `busy` is 0.
- R12: `half_period` is captured when a run starts. Changing it during a run does not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trigger | input | 1 | Starts a run when the block is idle |
| half_period | input | DIV_W | System clocks per SCL step (0 acts as 1) |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A recovery run is in progress |
| done | output | 1 | One-cycle pulse when the stop has completed |
| sda_free | output | 1 | SDA level sampled at the end of the last stop |

## Verification
The sequence is run with no slave on the bus, which shows that the pattern order and step lengths are exact. It is also run with a slave that keeps SDA low for a few clocks and then lets go, and with a slave that never lets go. These two cases separate a high `sda_free` from a low one, and show that the clock pattern does not depend on SDA. Random half periods, including zero, and random clock stretches of random length at random pulses check the cycle arithmetic. Changes to the divider and extra triggers during a run show that neither reaches the run already in progress.

// File: rtl/twi_recover_pkg.sv
package twi_recover_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_START,
    ST_HOLD,
    ST_LOW,
    ST_HIGH,
    ST_PRE_LOW,
    ST_RS_HIGH,
    ST_RS,
    ST_P_LOW,
    ST_P_HIGH,
    ST_STOP
  } step_e;

  typedef struct packed {
    logic scl_pull;
    logic sda_pull;
  } pull_t;

  // Line pulls belonging to each step; a 1 pulls the line low.
  function automatic pull_t step_pulls(step_e s);
    pull_t p;
    p = '{scl_pull: 1'b0, sda_pull: 1'b0};
    unique case (s)
      ST_START:   p.sda_pull = 1'b1;
      ST_HOLD:    begin p.scl_pull = 1'b1; p.sda_pull = 1'b1; end
      ST_LOW:     p.scl_pull = 1'b1;
      ST_PRE_LOW: p.scl_pull = 1'b1;
      ST_RS:      p.sda_pull = 1'b1;
      ST_P_LOW:   begin p.scl_pull = 1'b1; p.sda_pull = 1'b1; end
      ST_P_HIGH:  p.sda_pull = 1'b1;
      default:    p = '{scl_pull: 1'b0, sda_pull: 1'b0};
    endcase
    return p;
  endfunction

  // Steps during which SCL is released and must read high before counting.
  function automatic logic scl_released(step_e s);
    return (s != ST_IDLE) && !step_pulls(s).scl_pull;
  endfunction

endpackage

// File: rtl/twi_recover_timer.sv
module twi_recover_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [DIV_W-1:0] last_val,
  output logic             step_done
);

  logic [DIV_W-1:0] cnt_q;

  assign step_done = tick && (cnt_q == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear || step_done) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/twi_recover_fsm.sv
module twi_recover_fsm
  import twi_recover_pkg::*;
#(
  parameter int CLOCKS = 9
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  launch,
  input  logic  step_done,
  output step_e step_q,
  output step_e step_d,
  output logic  finish
);

  localparam int PW = $clog2(CLOCKS + 1);
  localparam logic [PW-1:0] LAST_PULSE = PW'(CLOCKS - 1);

  logic [PW-1:0] pulse_q;

  always_comb begin
    step_d = step_q;
    finish = 1'b0;
    if (step_q == ST_IDLE) begin
      if (launch) step_d = ST_SETUP;
    end else if (step_done) begin
      unique case (step_q)
        ST_SETUP:   step_d = ST_START;
        ST_START:   step_d = ST_HOLD;
        ST_HOLD:    step_d = ST_LOW;
        ST_LOW:     step_d = ST_HIGH;
        ST_HIGH:    step_d = (pulse_q == LAST_PULSE) ? ST_PRE_LOW : ST_LOW;
        ST_PRE_LOW: step_d = ST_RS_HIGH;
        ST_RS_HIGH: step_d = ST_RS;
        ST_RS:      step_d = ST_P_LOW;
        ST_P_LOW:   step_d = ST_P_HIGH;
        ST_P_HIGH:  step_d = ST_STOP;
        ST_STOP: begin
          step_d = ST_IDLE;
          finish = 1'b1;
        end
        default:    step_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= ST_IDLE;
      pulse_q <= '0;
    end else begin
      step_q <= step_d;
      if (step_q == ST_IDLE) begin
        pulse_q <= '0;
      end else if (step_done && step_q == ST_HIGH) begin
        pulse_q <= pulse_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/twi_recover_drive.sv
module twi_recover_drive
  import twi_recover_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  step_e step_d,
  input  logic  finish,
  input  logic  sda_in,
  output logic  scl_pull,
  output logic  sda_pull,
  output logic  done,
  output logic  sda_free
);

  pull_t pulls_d;

  assign pulls_d = step_pulls(step_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
      done     <= 1'b0;
      sda_free <= 1'b0;
    end else begin
      scl_pull <= pulls_d.scl_pull;
      sda_pull <= pulls_d.sda_pull;
      done     <= finish;
      if (finish) sda_free <= sda_in;
    end
  end

endmodule

// File: rtl/twi_recover_seq.sv
module twi_recover_seq
  import twi_recover_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int CLOCKS   = 9,
  parameter bit AUTO_RUN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigger,
  input  logic [DIV_W-1:0] half_period,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic             busy,
  output logic             done,
  output logic             sda_free
);

  step_e            step_q;
  step_e            step_d;
  logic             finish;
  logic             step_done;
  logic             launch;
  logic             pend;
  logic             tick;
  logic [DIV_W-1:0] hp_q;
  logic [DIV_W-1:0] last_val;

  generate
    if (AUTO_RUN) begin : g_auto
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pend_q <= 1'b1;
        else if (launch) pend_q <= 1'b0;
      end
      assign pend = pend_q;
    end else begin : g_manual
      assign pend = 1'b0;
    end
  endgenerate

  assign busy   = (step_q != ST_IDLE);
  assign launch = !busy && (trigger || pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hp_q <= '0;
    else if (launch) hp_q <= half_period;
  end

  assign last_val = (hp_q == '0) ? '0 : hp_q - 1'b1;
  assign tick     = busy && (!scl_released(step_q) || scl_in);

  twi_recover_timer #(.DIV_W(DIV_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (launch),
    .tick      (tick),
    .last_val  (last_val),
    .step_done (step_done)
  );

  twi_recover_fsm #(.CLOCKS(CLOCKS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .step_done (step_done),
    .step_q    (step_q),
    .step_d    (step_d),
    .finish    (finish)
  );

  twi_recover_drive u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_d   (step_d),
    .finish   (finish),
    .sda_in   (sda_in),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .done     (done),
    .sda_free (sda_free)
  );

endmodule

// File: rtl/twi_recover_chk.sv
module twi_recover_chk #(
  parameter int CLOCKS = 9
) (
  input logic clk,
  input logic rst_n,
  input logic trigger,
  input logic scl_in,
  input logic scl_pull,
  input logic sda_pull,
  input logic busy,
  input logic done
);

  localparam int RW = $clog2(CLOCKS + 3);

  logic          prev_scl;
  logic [RW-1:0] rel_cnt;
  logic [RW-1:0] rel_idx;
  logic          rel_now;

  assign rel_now = busy && prev_scl && !scl_pull;
  assign rel_idx = rel_cnt + RW'(rel_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_scl <= 1'b0;
      rel_cnt  <= '0;
    end else begin
      prev_scl <= scl_pull;
      if (!busy)        rel_cnt <= '0;
      else if (rel_now) rel_cnt <= rel_cnt + 1'b1;
    end
  end

  AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull && !sda_pull)); // R11

  AST_NO_JOINT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !((scl_pull != $past(scl_pull)) && (sda_pull != $past(sda_pull)))); // R11

  AST_CLOCK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rel_cnt == RW'(CLOCKS + 2))); // R4

  AST_SDA_FREE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scl_pull && rel_idx >= RW'(1) && rel_idx <= RW'(CLOCKS)) |-> !sda_pull); // R5

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scl_pull && !scl_in) |=> ($stable(scl_pull) && $stable(sda_pull))); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done)); // R9

  AST_TRIG_NO_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !trigger) |=> !busy); // R8

endmodule

bind twi_recover_seq twi_recover_chk #(.CLOCKS(CLOCKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trigger  (trigger),
  .scl_in   (scl_in),
  .scl_pull (scl_pull),
  .sda_pull (sda_pull),
  .busy     (busy),
  .done     (done)
);

// File: tb/twi_recover_seq_bench.sv
module twi_recover_seq_bench;

  localparam int DIV_W = 8;
  localparam int LIMIT = 4000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             trigger = 1'b0;
  logic [DIV_W-1:0] half_period = '0;
  logic             sl_scl = 1'b0;
  logic             sl_sda = 1'b0;
  logic             scl_in, sda_in;
  logic             scl_pull, sda_pull, busy, done, sda_free;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // per-run observations
  int  busy_cyc, rel, sfall, srise, viol, done_cnt, last_edge;
  bit  prev_scl, prev_sda, seen_done;

  always #2.5 clk = ~clk;

  assign scl_in = !(scl_pull || sl_scl);
  assign sda_in = !(sda_pull || sl_sda);

  twi_recover_seq u_twi_recover_seq (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .half_period(half_period),
    .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .busy(busy), .done(done), .sda_free(sda_free)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_busy(input int hp, input int k);
    return 27 * ((hp == 0) ? 1 : hp) + k;
  endfunction

  task automatic sample();
    if (busy) busy_cyc++;
    if (busy && prev_scl && !scl_pull) rel++;
    if (busy && !prev_scl && !scl_pull && !prev_sda && sda_pull) begin sfall++; last_edge = 0; end
    if (busy && !prev_scl && !scl_pull && prev_sda && !sda_pull) begin srise++; last_edge = 1; end
    if (busy && !scl_pull && rel >= 1 && rel <= 9 && sda_pull) viol++;
    if (done) begin done_cnt++; seen_done = 1'b1; end
    prev_scl = scl_pull;
    prev_sda = sda_pull;
  endtask

  // One recovery run; all stimulus is driven just after a falling edge.
  task automatic run(input int hp, input int hp_mid, input int k, input int k_at,
                     input bit trig_mid, input int sda_mode, input bit use_trig,
                     input string name);
    int st = 0;
    int rem = 0;
    busy_cyc = 0; rel = 0; sfall = 0; srise = 0; viol = 0; done_cnt = 0;
    last_edge = -1; seen_done = 1'b0;
    prev_scl = scl_pull; prev_sda = sda_pull;
    half_period = DIV_W'(hp);
    sl_sda = (sda_mode != 0);
    trigger = use_trig;
    for (int c = 0; c < LIMIT && !seen_done; c++) begin
      @(negedge clk);
      trigger = 1'b0;
      sample();
      if (c == 3) half_period = DIV_W'(hp_mid);
      if (trig_mid && c == 10) trigger = 1'b1;
      if (k > 0) begin
        if (st == 0 && rel == k_at && scl_pull) begin sl_scl = 1'b1; st = 1; end
        else if (st == 1 && !scl_pull) begin rem = k; st = 2; end
        else if (st == 2) begin
          rem--;
          if (rem == 0) begin sl_scl = 1'b0; st = 3; end
        end
      end
      if (sda_mode == 1 && rel >= 3 && scl_pull) sl_sda = 1'b0;
    end
    trigger = 1'b0;
    chk(seen_done && done_cnt == 1, {"R9 done pulse ", name}, done_cnt, 1);
    chk(busy_cyc == exp_busy(hp, k), {"R6 R7 busy length ", name}, busy_cyc, exp_busy(hp, k));
    chk(rel == 11, {"R4 SCL releases ", name}, rel, 11);
    chk(sfall == 2 && srise == 1 && last_edge == 1, {"R3 start/Sr/stop edges ", name},
        sfall * 10 + srise, 21);
    chk(viol == 0, {"R5 SDA pulled in clock high ", name}, viol, 0);
    chk(sda_free == (sda_mode != 2), {"R10 sda_free ", name}, sda_free, (sda_mode != 2));
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(!busy && !done && !scl_pull && !sda_pull, {"R8 R11 idle after run ", name},
          {busy, done, scl_pull, sda_pull}, 0);
    end
    chk(sda_free == (sda_mode != 2), {"R10 sda_free held ", name}, sda_free, (sda_mode != 2));
    sl_sda = 1'b0;
    sl_scl = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    half_period = 8'd2;
    repeat (3) @(negedge clk);
    chk(!scl_pull && !sda_pull && !busy && !done, "R1 reset outputs",
        {scl_pull, sda_pull, busy, done}, 0);
    rst_n = 1'b1;
    chk(!scl_pull && !sda_pull && !busy && !done, "R1 first cycle after reset",
        {scl_pull, sda_pull, busy, done}, 0);
    // R2: automatic run after reset, no trigger
    run(2, 2, 0, 0, 0, 0, 0, "auto");

    // directed corner cases
    run(0, 0, 0, 0, 0, 0, 1, "hp0");
    run(1, 1, 0, 0, 0, 1, 1, "stuck_then_free");
    run(3, 3, 0, 0, 0, 2, 1, "stuck_forever");
    run(2, 9, 0, 0, 1, 0, 1, "R12 hp change and R8 mid trigger");
    run(1, 1, 5, 4, 0, 0, 1, "stretch");

    // random runs
    for (int i = 0; i < 30; i++) begin
      int hp, k, kat, mode;
      bit tm;
      hp   = $urandom_range(0, 6);
      k    = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, 6);
      kat  = $urandom_range(1, 8);
      mode = $urandom_range(0, 2);
      tm   = $urandom_range(0, 1);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      run(hp, $urandom_range(0, 15), k, kat, tm, mode, 1, "random");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule